// File: doc/BRIEF.md
# DMA Channel Request Front End with Rate Governor

This block sits in front of one DMA channel and decides, clock by clock, whether that channel asks the bus arbiter for the bus. It accepts a transfer request from off chip, which may arrive at any time, and brings it into the clock domain through a synchronizer. It then turns the request into a bus request according to the selected mode. In burst mode the request is a level: the channel keeps asking for as long as the synchronized request stays high. In cycle-steal mode each separate assertion buys one transfer, and the request must be seen on two consecutive samples. In internal-request mode the off-chip line is ignored and the channel asks whenever it runs.

A channel runs from the rising edge of its start bit until the start bit drops or a done pulse arrives. It does not start when the programmed byte count is zero or is not a whole number of the wider port's operands. A rate governor can cap bus usage. The channel may own the bus for a programmed number of clocks in which it is granted. It must then stay off the bus for a programmed number of clocks, counted whether or not the bus is busy. Setting the active limit to zero turns the governor off.

Top module: `dma_req_limiter`

## Requirements
- R1: The off-chip request passes two synchronizer flops. In burst mode, on a running and unthrottled channel, `bus_req` follows a change of `ext_req` on the third rising edge after the change.
- R2: In cycle-steal mode a request is recognized only when the synchronized request is high on two consecutive clocks. A pulse lasting one clock produces no bus request.
- R3: If `ext_req` is already high when `start` rises, the channel treats the request as a fresh assertion and makes one cycle-steal request without a new edge on `ext_req`.
- R4: In cycle-steal mode a recognized request stays pending until a clock in which `bus_grant`, `bus_req` and `cycle_done` are all high. A request held high does not produce a second one until `ext_req` goes low and high again.
- R5: In burst mode a request still high when a cycle completes keeps `bus_req` asserted, so the next transfer follows.
- R6: With `int_mode` high, `bus_req` is high whenever the channel runs and is not throttled, whatever the state of `ext_req`.
- R7: A high `done_in` at a rising edge clears `running` and `bus_req` at that edge. The channel stays stopped until `start` falls and rises again.
- R8: `port_size` encodes the wider port: 0 is byte, 1 is 16-bit, 2 is 32-bit and 3 is invalid. A byte count of zero, an invalid size, or a count that is not a multiple of 1, 2 or 4 bytes respectively raises `cfg_err` one clock later and stops the channel from starting.
- R9: The active count advances only on clocks where `bus_grant` and `bus_req` are both high. Without a grant it holds, and the channel is never throttled.
- R10: After `active_limit` granted clocks, `throttled` goes high and `bus_req` low for max(`idle_limit`,1) clocks, regardless of the grant. After that both counts restart from zero.
- R11: With `active_limit` zero, the channel is never throttled.
- R12: Reset clears all outputs, and a low `start` clears `running`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | 1 | Off-chip transfer request, asynchronous |
| done_in | input | 1 | Terminates channel operation |
| start | input | 1 | Channel start bit, the run begins on its rising edge |
| cs_mode | input | 1 | 1 selects cycle steal, 0 selects burst |
| int_mode | input | 1 | 1 selects internal request generation |
| port_size | input | 2 | Wider port size code (0 byte, 1 16-bit, 2 32-bit) |
| byte_count | input | CNT_W | Programmed transfer byte count |
| active_limit | input | ACT_W | Granted clocks allowed per window, 0 turns the governor off |
| idle_limit | input | IDL_W | Off-bus clocks after the window ends |
| bus_grant | input | 1 | Arbiter grant to this channel |
| cycle_done | input | 1 | Current bus cycle completes |
| bus_req | output | 1 | Registered bus request to the arbiter |
| running | output | 1 | Channel is running |
| throttled | output | 1 | Channel is in its forced idle window |
| cfg_err | output | 1 | Configuration error flag |

## Verification
A wrong synchronizer depth or a lost pending flag shows up directly at `bus_req`. The request rises or falls one clock off from the reference, or a transfer is dropped or repeated, within three clocks of the stimulus. A governor count that advances without a grant, or that skips its idle clocks, moves the edges of `throttled` against the reference. This appears within one active-plus-idle window. A bad start-edge or done path shows in `running` on the next clock.

// File: rtl/dma_rl_pkg.sv
package dma_rl_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } port_sz_e;
endpackage

// File: rtl/dma_rl_sync.sv
module dma_rl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/dma_rl_cfgchk.sv
module dma_rl_cfgchk
  import dma_rl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [1:0]       port_size,
  output logic             bad_now,
  output logic             cfg_err
);
  logic [1:0] lsb_mask;

  always_comb begin
    case (port_sz_e'(port_size))
      SZ_WORD: lsb_mask = 2'b01;
      SZ_LONG: lsb_mask = 2'b11;
      default: lsb_mask = 2'b00;
    endcase
    bad_now = (byte_count == '0) || (port_sz_e'(port_size) == SZ_RSVD) ||
              ((byte_count[1:0] & lsb_mask) != 2'b00);
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= bad_now;
  end
endmodule

// File: rtl/dma_rl_rategov.sv
module dma_rl_rategov #(
  parameter int ACT_W = 8,
  parameter int IDL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_next,
  input  logic             own,
  input  logic [ACT_W-1:0] active_limit,
  input  logic [IDL_W-1:0] idle_limit,
  output logic             idle_next,
  output logic             throttled
);
  logic [ACT_W-1:0] act_q, act_n;
  logic [IDL_W-1:0] idl_q, idl_n;
  logic [ACT_W:0]   act_inc;
  logic [IDL_W:0]   idl_inc;
  logic             gov_on;

  assign gov_on  = (active_limit != '0);
  assign act_inc = {1'b0, act_q} + 1'b1;
  assign idl_inc = {1'b0, idl_q} + 1'b1;

  always_comb begin
    act_n     = act_q;
    idl_n     = idl_q;
    idle_next = throttled;
    if (!run_next || !gov_on) begin
      act_n     = '0;
      idl_n     = '0;
      idle_next = 1'b0;
    end else if (throttled) begin
      if (idl_inc >= {1'b0, idle_limit}) begin
        idl_n     = '0;
        idle_next = 1'b0;
      end else begin
        idl_n = idl_inc[IDL_W-1:0];
      end
    end else if (own) begin
      if (act_inc >= {1'b0, active_limit}) begin
        act_n     = '0;
        idle_next = 1'b1;
      end else begin
        act_n = act_inc[ACT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= '0;
      idl_q     <= '0;
      throttled <= 1'b0;
    end else begin
      act_q     <= act_n;
      idl_q     <= idl_n;
      throttled <= idle_next;
    end
  end

  // R9: without ownership the active count holds
  p_act_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (run_next && gov_on && !throttled && !own) |=> $stable(act_q));

  // R10: idle window is not cut short while clocks remain
  p_idle_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (run_next && gov_on && throttled && (idl_inc < {1'b0, idle_limit})) |=> throttled);
endmodule

// File: rtl/dma_req_limiter.sv
module dma_req_limiter #(
  parameter int CNT_W   = 16,
  parameter int ACT_W   = 8,
  parameter int IDL_W   = 8,
  parameter int SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_req,
  input  logic             done_in,
  input  logic             start,
  input  logic             cs_mode,
  input  logic             int_mode,
  input  logic [1:0]       port_size,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [ACT_W-1:0] active_limit,
  input  logic [IDL_W-1:0] idle_limit,
  input  logic             bus_grant,
  input  logic             cycle_done,
  output logic             bus_req,
  output logic             running,
  output logic             throttled,
  output logic             cfg_err
);
  logic req_s, req_d, start_q;
  logic seen_q, seen_n, pend_q, pend_n;
  logic run_n, start_rise, hit, own, want, cfg_bad, idle_next;

  dma_rl_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst(rst), .async_in(ext_req), .sync_out(req_s)
  );

  dma_rl_cfgchk #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .byte_count(byte_count), .port_size(port_size),
    .bad_now(cfg_bad), .cfg_err(cfg_err)
  );

  dma_rl_rategov #(.ACT_W(ACT_W), .IDL_W(IDL_W)) u_gov (
    .clk(clk), .rst(rst), .run_next(run_n), .own(own),
    .active_limit(active_limit), .idle_limit(idle_limit),
    .idle_next(idle_next), .throttled(throttled)
  );

  assign start_rise = start && !start_q;
  assign own        = bus_grant && bus_req;
  assign hit        = running && req_s && req_d && !seen_q;

  always_comb begin
    if (!start || done_in)            run_n = 1'b0;
    else if (start_rise && !cfg_bad)  run_n = 1'b1;
    else                              run_n = running;

    if (!req_s || start_rise) seen_n = 1'b0;
    else if (hit)             seen_n = 1'b1;
    else                      seen_n = seen_q;

    if (!run_n)                   pend_n = 1'b0;
    else if (hit)                 pend_n = 1'b1;
    else if (own && cycle_done)   pend_n = 1'b0;
    else                          pend_n = pend_q;

    want = int_mode || (cs_mode ? pend_n : req_s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d   <= 1'b0;
      start_q <= 1'b0;
      running <= 1'b0;
      seen_q  <= 1'b0;
      pend_q  <= 1'b0;
      bus_req <= 1'b0;
    end else begin
      req_d   <= req_s;
      start_q <= start;
      running <= run_n;
      seen_q  <= seen_n;
      pend_q  <= pend_n;
      bus_req <= run_n && !idle_next && want;
    end
  end

  // R12: no request from a stopped channel
  p_req_needs_run_r12: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> running);

  // R10: no request in the idle window
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (rst)
    throttled |-> !bus_req);

  // R7: done stops the channel at once
  p_done_stop_r7: assert property (@(posedge clk) disable iff (rst)
    done_in |=> (!running && !bus_req));

  // R8: a channel never starts on a bad configuration
  p_cfg_start_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> !cfg_err);
endmodule

// File: tb/dma_req_limiter_bench.sv
`timescale 1ns/1ps
module dma_req_limiter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_req = 0, done_in = 0, start = 0, cs_mode = 0, int_mode = 0;
  logic [1:0]  port_size = 2'd1;
  logic [15:0] byte_count = 16'd16;
  logic [7:0]  active_limit = 8'd0, idle_limit = 8'd0;
  logic bus_grant = 0, cycle_done = 0;
  logic bus_req, running, throttled, cfg_err;

  int checks = 0, errors = 0;
  string tag = "R12";
  bit finished = 0, armed = 0;

  always #2.5 clk = ~clk;

  dma_req_limiter u_dma_req_limiter (
    .clk(clk), .rst(rst), .ext_req(ext_req), .done_in(done_in), .start(start),
    .cs_mode(cs_mode), .int_mode(int_mode), .port_size(port_size),
    .byte_count(byte_count), .active_limit(active_limit), .idle_limit(idle_limit),
    .bus_grant(bus_grant), .cycle_done(cycle_done), .bus_req(bus_req),
    .running(running), .throttled(throttled), .cfg_err(cfg_err)
  );

  // behavioural reference
  int s_hist[$];
  int m_req = 0, m_run = 0, m_thr = 0, m_err = 0;
  int m_prev_start = 0, m_prev_sync = 0, m_used = 0, m_pend = 0, m_act = 0, m_idl = 0;

  initial s_hist = '{0, 0};

  always @(posedge clk) begin
    int bad, rise, nrun, synced, hit, own, npend, nthr, want, unit;
    if (rst) begin
      s_hist = '{0, 0};
      m_req = 0; m_run = 0; m_thr = 0; m_err = 0; m_prev_start = 0;
      m_prev_sync = 0; m_used = 0; m_pend = 0; m_act = 0; m_idl = 0;
    end else begin
      unit = 1 << port_size;
      bad = (byte_count == 0) || (port_size == 3) || ((byte_count % unit) != 0);
      rise = start && !m_prev_start;
      nrun = (!start || done_in) ? 0 : ((rise && !bad) ? 1 : m_run);
      synced = s_hist[0];
      hit = m_run && synced && m_prev_sync && !m_used;
      own = bus_grant && m_req;
      npend = !nrun ? 0 : (hit ? 1 : ((own && cycle_done) ? 0 : m_pend));
      nthr = m_thr;
      if (!nrun || active_limit == 0) begin
        nthr = 0; m_act = 0; m_idl = 0;
      end else if (m_thr) begin
        if (m_idl + 1 >= idle_limit) begin nthr = 0; m_idl = 0; end
        else m_idl++;
      end else if (own) begin
        if (m_act + 1 >= active_limit) begin nthr = 1; m_act = 0; end
        else m_act++;
      end
      want = int_mode || (cs_mode ? npend : synced);
      m_used = (!synced || rise) ? 0 : (hit ? 1 : m_used);
      m_req = nrun && !nthr && want;
      m_err = bad;
      m_run = nrun; m_pend = npend; m_thr = nthr;
      m_prev_sync = synced; m_prev_start = start;
      void'(s_hist.pop_front());
      s_hist.push_back(int'(ext_req));
    end
    armed = 1;
  end

  task automatic chk(input string t, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !finished) begin
      chk(tag, "bus_req", bus_req, m_req);
      chk(tag, "running", running, m_run);
      chk(tag, "throttled", throttled, m_thr);
      chk(tag, "cfg_err", cfg_err, m_err);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    step(3);
    rst = 0;
    step(1);
    tag = "R12";
    chk("R12", "reset bus_req", bus_req, 0);
    chk("R12", "reset running", running, 0);

    // R1 / R5 / R11: burst, governor off
    tag = "R1";
    bus_grant = 1; start = 1; ext_req = 1;
    step(2); chk("R1", "req before 3rd edge", bus_req, 0);
    step(1); chk("R1", "req at 3rd edge", bus_req, 1);
    tag = "R5";
    cycle_done = 1; step(3); chk("R5", "burst continues", bus_req, 1);
    cycle_done = 0;
    tag = "R1";
    ext_req = 0; step(2); chk("R1", "drop before 3rd edge", bus_req, 1);
    step(1); chk("R1", "drop at 3rd edge", bus_req, 0);

    // R7: done
    tag = "R7";
    ext_req = 1; step(4);
    done_in = 1; step(1); done_in = 0;
    chk("R7", "running after done", running, 0);
    step(3); chk("R7", "stays stopped", running, 0);
    chk("R7", "no request", bus_req, 0);

    // R12: start low, then R8 configuration errors
    tag = "R12";
    start = 0; step(2); chk("R12", "running with start low", running, 0);
    tag = "R8";
    byte_count = 16'd3; start = 1; step(2);
    chk("R8", "odd count word port", cfg_err, 1);
    chk("R8", "no start", running, 0);
    start = 0; byte_count = 16'd0; step(1); start = 1; step(2);
    chk("R8", "zero count", cfg_err, 1);
    start = 0; byte_count = 16'd8; port_size = 2'd3; step(1); start = 1; step(2);
    chk("R8", "invalid size", cfg_err, 1);
    start = 0; port_size = 2'd2; step(1); start = 1; step(2);
    chk("R8", "long port ok", cfg_err, 0);
    chk("R8", "starts", running, 1);
    start = 0; byte_count = 16'd6; step(1); start = 1; step(2);
    chk("R8", "6 bytes long port", cfg_err, 1);
    byte_count = 16'd16; port_size = 2'd1;

    // R2: cycle steal recognition
    tag = "R2";
    start = 0; ext_req = 0; cs_mode = 1; step(1);
    start = 1; step(4);
    ext_req = 1; step(1); ext_req = 0; step(6);
    chk("R2", "one-clock pulse ignored", bus_req, 0);
    ext_req = 1; step(5);
    chk("R2", "held request recognized", bus_req, 1);

    // R4: one transfer per assertion
    tag = "R4";
    cycle_done = 1; step(1); cycle_done = 0; step(3);
    chk("R4", "cleared and not re-armed", bus_req, 0);
    ext_req = 0; step(3); ext_req = 1; step(5);
    chk("R4", "new assertion", bus_req, 1);
    cycle_done = 1; step(1); cycle_done = 0;

    // R3: request already held at start
    tag = "R3";
    start = 0; step(2); start = 1; step(5);
    chk("R3", "synthetic start edge", bus_req, 1);

    // R6: internal request
    tag = "R6";
    start = 0; step(1);
    int_mode = 1; cs_mode = 0; ext_req = 0; start = 1; step(3);
    chk("R6", "internal request", bus_req, 1);

    // R9: no grant, no progress
    tag = "R9";
    active_limit = 8'd3; idle_limit = 8'd4; bus_grant = 0;
    step(20);
    chk("R9", "never throttled w/o grant", throttled, 0);
    chk("R9", "still requesting", bus_req, 1);
    for (int i = 0; i < 40; i++) begin
      bus_grant = (i % 3) != 0;
      step(1);
    end

    // R10: windows with grant held, then zero idle limit
    tag = "R10";
    bus_grant = 1;
    begin
      int seen_thr = 0;
      for (int i = 0; i < 30; i++) begin
        step(1);
        if (throttled) seen_thr++;
      end
      chk("R10", "throttle seen", int'(seen_thr > 0), 1);
    end
    idle_limit = 8'd0; step(20);
    active_limit = 8'd1; idle_limit = 8'd2; step(20);

    // R11: governor off
    tag = "R11";
    active_limit = 8'd0; step(2);
    begin
      int any = 0;
      for (int i = 0; i < 20; i++) begin
        step(1);
        if (throttled) any = 1;
      end
      chk("R11", "never throttled", any, 0);
    end
    chk("R11", "requesting", bus_req, 1);

    step(2);
    finish_run();
  end
endmodule